// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt lines and a software interrupt mask, and chooses one source to present to the processor. Each source has its own configuration word, which gives its priority level, a non-maskable flag and the register set its handler should use. Enable and software masks can be replaced outright through one offset. Two further offsets set or clear selected bits, so firmware never needs a read-modify-write.

On every clock the block combines the sampled lines with the software mask and gates the result with the enable mask. Among the enabled pending sources it picks the one with the highest nonzero level. It then registers a request packet for the processor: the handler address (table base plus index times a programmable entry size), the register set, the level and the non-maskable flag, together with a request line.

The packet is a plain level interface with no back-pressure. It stays valid for as long as `req_o` is high and changes only when the winner or its configuration changes. The register bus is a simple strobe interface. A write completes at the edge where `wr_en_i` is high. Read data appears on the edge after `rd_en_i` and holds until the next read.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every readable offset (0 to 63) reads zero and `req_o`, `req_addr_o`, `req_regset_o`, `req_level_o`, `req_nmi_o` are zero.
- R2: Writing word offsets 0 to 31 stores a full 32-bit configuration word for that source, readable back unchanged. Bits 5:0 are the level, bit 6 the non-maskable flag and bits 12:7 the register set; the packet carries these fields of the winning source.
- R3: Offset 36 reads the interrupt lines as sampled on each clock. Offset 35 reads (sampled lines OR software mask) AND enable mask.
- R4: The winner is the pending source with the highest level. On equal levels the lowest index wins, and a source with level 0 never wins.
- R5: The handler address, also readable at offset 43, equals the table base (offset 42) plus winner index times (4 shifted left by bits 2:0 of the controller configuration at offset 40), modulo 2^32.
- R6: While a source wins, offset 41 reads the winner index in its low bits with bit 31 set and `req_o` is high. With no winner, offsets 41 and 43 read zero and the whole packet is zero.
- R7: Offset 32 replaces the enable mask, offset 33 ORs the written value into it, and offset 34 clears the bits written as one.
- R8: Offset 37 replaces the software mask, offset 38 ORs into it, and offset 39 clears the bits written as one.
- R9: Writes to offsets 35, 36, 41, 43 and 44 to 63 change no state. Reads of offsets 33, 34, 38, 39 and 44 to 63 return zero.
- R10: A register write at one edge shows in the packet at the following edge. A line change is sampled at the next edge and reaches the packet one edge later. `rdata_o` is updated one cycle after `rd_en_i` and holds while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Level-sensitive interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the strobe |
| req_o | output | 1 | Interrupt request to the processor |
| req_addr_o | output | 32 | Handler address of the winner |
| req_regset_o | output | 6 | Register set of the winner |
| req_level_o | output | 6 | Level of the winner |
| req_nmi_o | output | 1 | Non-maskable flag of the winner |

## Verification
A corrupted mask bit or configuration word shows on the packet pins at the next edge, because the wrong source wins, no source wins, or the address uses the wrong index or stride. A wrong sampled line shows one edge later. Status and vector address are read back through the bus after every stimulus, so a mismatch between the packet and the readable copies is caught at once. Sweeps drive each source alone with a different stride and base, and then test ties, level-zero sources and the alias offsets.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int LVL_W   = 6;
  localparam int RS_W    = 6;
  localparam int NMI_BIT = 6;
  localparam int RS_LSB  = 7;
  localparam int STRIDE_W = 3;
  localparam int STRIDE_MIN_SHIFT = 2;

  localparam logic [ADDR_W-1:0] CSR_ENA      = 6'd32;
  localparam logic [ADDR_W-1:0] CSR_ENA_SET  = 6'd33;
  localparam logic [ADDR_W-1:0] CSR_ENA_CLR  = 6'd34;
  localparam logic [ADDR_W-1:0] CSR_PEND     = 6'd35;
  localparam logic [ADDR_W-1:0] CSR_RAW      = 6'd36;
  localparam logic [ADDR_W-1:0] CSR_SOFT     = 6'd37;
  localparam logic [ADDR_W-1:0] CSR_SOFT_SET = 6'd38;
  localparam logic [ADDR_W-1:0] CSR_SOFT_CLR = 6'd39;
  localparam logic [ADDR_W-1:0] CSR_CTRL     = 6'd40;
  localparam logic [ADDR_W-1:0] CSR_STAT     = 6'd41;
  localparam logic [ADDR_W-1:0] CSR_BASE     = 6'd42;
  localparam logic [ADDR_W-1:0] CSR_VADDR    = 6'd43;

  typedef struct packed {
    logic              req;
    logic [DATA_W-1:0] hndl;
    logic [RS_W-1:0]   rs;
    logic [LVL_W-1:0]  lvl;
    logic              nmi;
  } req_pkt_t;
endpackage

// File: rtl/virq_regs.sv
module virq_regs
  import virq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            irq_i,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [DATA_W-1:0]             stat_i,
  input  logic [DATA_W-1:0]             vaddr_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_SRC-1:0]            pend_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o,
  output logic [NUM_SRC-1:0][RS_W-1:0]  rs_o,
  output logic [NUM_SRC-1:0]            nmi_o,
  output logic [DATA_W-1:0]             base_o,
  output logic [STRIDE_W-1:0]           stride_o
);
  localparam int CFG_IDX_W = ADDR_W - 1;

  logic [NUM_SRC-1:0][DATA_W-1:0] cfg_q;
  logic [NUM_SRC-1:0] ena_q, soft_q, raw_q;
  logic [DATA_W-1:0]  ctrl_q, base_q, rd_mux;
  logic               is_cfg;
  logic [CFG_IDX_W-1:0] cfg_idx;

  assign is_cfg  = (addr_i[ADDR_W-1] == 1'b0) && (int'(addr_i[CFG_IDX_W-1:0]) < NUM_SRC);
  assign cfg_idx = addr_i[CFG_IDX_W-1:0];
  assign pend_o  = (raw_q | soft_q) & ena_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ena_q  <= '0;
      soft_q <= '0;
      raw_q  <= '0;
      ctrl_q <= '0;
      base_q <= '0;
    end else begin
      raw_q <= irq_i;
      if (wr_en_i) begin
        if (is_cfg) cfg_q[cfg_idx] <= wdata_i;
        else begin
          case (addr_i)
            CSR_ENA:      ena_q  <= wdata_i[NUM_SRC-1:0];
            CSR_ENA_SET:  ena_q  <= ena_q | wdata_i[NUM_SRC-1:0];
            CSR_ENA_CLR:  ena_q  <= ena_q & ~wdata_i[NUM_SRC-1:0];
            CSR_SOFT:     soft_q <= wdata_i[NUM_SRC-1:0];
            CSR_SOFT_SET: soft_q <= soft_q | wdata_i[NUM_SRC-1:0];
            CSR_SOFT_CLR: soft_q <= soft_q & ~wdata_i[NUM_SRC-1:0];
            CSR_CTRL:     ctrl_q <= wdata_i;
            CSR_BASE:     base_q <= wdata_i;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_cfg) rd_mux = cfg_q[cfg_idx];
    else begin
      case (addr_i)
        CSR_ENA:   rd_mux = DATA_W'(ena_q);
        CSR_PEND:  rd_mux = DATA_W'(pend_o);
        CSR_RAW:   rd_mux = DATA_W'(raw_q);
        CSR_SOFT:  rd_mux = DATA_W'(soft_q);
        CSR_CTRL:  rd_mux = ctrl_q;
        CSR_STAT:  rd_mux = stat_i;
        CSR_BASE:  rd_mux = base_q;
        CSR_VADDR: rd_mux = vaddr_i;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fields
    assign lvl_o[g] = cfg_q[g][LVL_W-1:0];
    assign rs_o[g]  = cfg_q[g][RS_LSB+RS_W-1:RS_LSB];
    assign nmi_o[g] = cfg_q[g][NMI_BIT];
  end

  assign base_o   = base_q;
  assign stride_o = ctrl_q[STRIDE_W-1:0];

  a_r7_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == CSR_ENA_SET) |=> ((ena_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));
  a_r7_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == CSR_ENA_CLR) |=> ((ena_q & $past(wdata_i[NUM_SRC-1:0])) == '0));
  a_r8_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == CSR_SOFT_CLR) |=> ((soft_q & $past(wdata_i[NUM_SRC-1:0])) == '0));
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/virq_arbiter.sv
module virq_arbiter
  import virq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                          win_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    best_lvl = '0;
    idx_o    = '0;
    win_o    = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (lvl_i[i] > best_lvl)) begin
        best_lvl = lvl_i[i];
        idx_o    = IDX_W'(i);
        win_o    = 1'b1;
      end
    end
  end

  a_r4_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> (pend_i[idx_o] && lvl_i[idx_o] != '0));
  a_r4_none_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !win_o);
endmodule

// File: rtl/virq_packet.sv
module virq_packet
  import virq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          win_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [NUM_SRC-1:0][RS_W-1:0]  rs_i,
  input  logic [NUM_SRC-1:0]            nmi_i,
  input  logic [DATA_W-1:0]             base_i,
  input  logic [STRIDE_W-1:0]           stride_i,
  output req_pkt_t                      pkt_o,
  output logic [DATA_W-1:0]             stat_o
);
  req_pkt_t          nxt;
  logic [DATA_W-1:0] stat_nxt;

  always_comb begin
    nxt      = '0;
    stat_nxt = '0;
    if (win_i) begin
      nxt.req  = 1'b1;
      nxt.hndl = base_i + (DATA_W'(idx_i) << (STRIDE_MIN_SHIFT + int'(stride_i)));
      nxt.rs   = rs_i[idx_i];
      nxt.lvl  = lvl_i[idx_i];
      nxt.nmi  = nmi_i[idx_i];
      stat_nxt = DATA_W'(idx_i);
      stat_nxt[DATA_W-1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_o  <= '0;
      stat_o <= '0;
    end else begin
      pkt_o  <= nxt;
      stat_o <= stat_nxt;
    end
  end

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_o.req |-> (stat_o == '0 && pkt_o.hndl == '0 && pkt_o.lvl == '0));
  a_r10_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    win_i |=> (pkt_o.req && stat_o[DATA_W-1]));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import virq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              req_o,
  output logic [DATA_W-1:0] req_addr_o,
  output logic [RS_W-1:0]   req_regset_o,
  output logic [LVL_W-1:0]  req_level_o,
  output logic              req_nmi_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]            pend;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [NUM_SRC-1:0][RS_W-1:0]  rs;
  logic [NUM_SRC-1:0]            nmi;
  logic [DATA_W-1:0]             base, stat;
  logic [STRIDE_W-1:0]           stride;
  logic                          win;
  logic [IDX_W-1:0]              idx;
  req_pkt_t                      pkt;

  virq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .stat_i(stat), .vaddr_i(pkt.hndl),
    .rdata_o(rdata_o), .pend_o(pend), .lvl_o(lvl), .rs_o(rs), .nmi_o(nmi),
    .base_o(base), .stride_o(stride)
  );

  virq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .lvl_i(lvl), .win_o(win), .idx_o(idx)
  );

  virq_packet #(.NUM_SRC(NUM_SRC)) u_pkt (
    .clk(clk), .rst_n(rst_n), .win_i(win), .idx_i(idx), .lvl_i(lvl), .rs_i(rs),
    .nmi_i(nmi), .base_i(base), .stride_i(stride), .pkt_o(pkt), .stat_o(stat)
  );

  assign req_o        = pkt.req;
  assign req_addr_o   = pkt.hndl;
  assign req_regset_o = pkt.rs;
  assign req_level_o  = pkt.lvl;
  assign req_nmi_o    = pkt.nmi;
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, req_addr_o;
  logic        req_o, req_nmi_o;
  logic [5:0]  req_regset_o, req_level_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_cfg [32];
  logic [31:0] m_en, m_sw, m_raw, m_ctrl, m_base;

  always #2 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .req_o(req_o),
    .req_addr_o(req_addr_o), .req_regset_o(req_regset_o), .req_level_o(req_level_o),
    .req_nmi_o(req_nmi_o)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] m_pend();
    return (m_raw | m_sw) & m_en;
  endfunction

  function automatic int m_win();
    int best = -1;
    int bl = 0;
    logic [31:0] p = m_pend();
    for (int i = 0; i < 32; i++)
      if (p[i] && int'(m_cfg[i][5:0]) > bl) begin bl = int'(m_cfg[i][5:0]); best = i; end
    return best;
  endfunction

  function automatic logic [31:0] m_vaddr();
    int w = m_win();
    if (w < 0) return 32'd0;
    return m_base + (32'(w) << (2 + int'(m_ctrl[2:0])));
  endfunction

  function automatic logic [31:0] m_stat();
    int w = m_win();
    if (w < 0) return 32'd0;
    return 32'h8000_0000 | 32'(w);
  endfunction

  function automatic logic [31:0] m_rd(input int a);
    if (a < 32) return m_cfg[a];
    case (a)
      32: return m_en;
      35: return m_pend();
      36: return m_raw;
      37: return m_sw;
      40: return m_ctrl;
      41: return m_stat();
      42: return m_base;
      43: return m_vaddr();
      default: return 32'd0;
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 6'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a < 32) m_cfg[a] = d;
    else case (a)
      32: m_en = d;
      33: m_en = m_en | d;
      34: m_en = m_en & ~d;
      37: m_sw = d;
      38: m_sw = m_sw | d;
      39: m_sw = m_sw & ~d;
      40: m_ctrl = d;
      42: m_base = d;
      default: ;
    endcase
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = 6'(a);
    @(negedge clk);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk);
    irq_i = v;
    @(negedge clk);
    m_raw = v;
  endtask

  task automatic check_all(input string r);
    logic [31:0] v;
    int w;
    @(negedge clk);
    w = m_win();
    chk({r, " req"}, 32'(req_o), 32'(w >= 0));
    chk({r, " addr"}, req_addr_o, m_vaddr());
    chk({r, " regset"}, 32'(req_regset_o), (w >= 0) ? 32'(m_cfg[w][12:7]) : 32'd0);
    chk({r, " level"}, 32'(req_level_o), (w >= 0) ? 32'(m_cfg[w][5:0]) : 32'd0);
    chk({r, " nmi"}, 32'(req_nmi_o), (w >= 0) ? 32'(m_cfg[w][6]) : 32'd0);
    rd(41, v); chk({r, " status R6"}, v, m_stat());
    rd(43, v); chk({r, " vaddr R5"}, v, m_vaddr());
    rd(35, v); chk({r, " pending R3"}, v, m_pend());
  endtask

  task automatic sweep_reads(input string r);
    logic [31:0] v;
    for (int a = 0; a < 64; a++) begin
      rd(a, v);
      chk($sformatf("%s offset %0d", r, a), v, m_rd(a));
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        old_req;
    for (int i = 0; i < 32; i++) m_cfg[i] = '0;
    m_en = '0; m_sw = '0; m_raw = '0; m_ctrl = '0; m_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on all offsets and packet pins
    chk("R1 req", 32'(req_o), 32'd0);
    chk("R1 addr", req_addr_o, 32'd0);
    sweep_reads("R1 reset");

    // R2: configuration words stored and read back whole
    for (int i = 0; i < 32; i++)
      wr(i, 32'hA5A5_0000 ^ (32'(i) * 32'h0001_0203));
    sweep_reads("R2 cfg readback R9");

    // R4 R5 R6 R2: each source alone, different stride and base each time
    for (int i = 0; i < 32; i++)
      wr(i, (32'((i + 3) % 64) << 7) | (32'(i % 2) << 6) | 32'((i % 63) + 1));
    wr(32, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      wr(40, 32'(i % 8));
      wr(42, 32'h1000 + 32'(i) * 32'h0000_0104);
      set_irq(32'd1 << i);
      check_all($sformatf("R4 R5 R2 single src %0d", i));
    end
    wr(40, 32'd7);
    wr(42, 32'hFFFF_FF00);
    set_irq(32'd1 << 31);
    check_all("R5 address wrap");

    // R4: all lines on, highest level is source 31 (level 32)
    set_irq(32'hFFFF_FFFF);
    check_all("R4 all on");
    // R4: tie at top level, lowest index wins
    wr(9, 32'h0000_003F);
    wr(5, 32'h0000_1FFF);
    check_all("R4 tie low index");
    // R4: level-zero source never wins
    wr(5, 32'h0000_1F80);
    wr(9, 32'h0000_0040);
    set_irq((32'd1 << 5) | (32'd1 << 9));
    check_all("R4 level zero ignored");

    // R7: enable replace, set, clear aliases
    set_irq(32'h0000_0F00);
    wr(32, 32'd0);
    check_all("R7 all disabled");
    wr(33, 32'h0000_0300);
    rd(32, v); chk("R7 set alias", v, 32'h0000_0300);
    check_all("R7 after set");
    wr(34, 32'h0000_0200);
    rd(32, v); chk("R7 clear alias", v, 32'h0000_0100);
    check_all("R7 after clear");
    wr(32, 32'hFFFF_FFFF);

    // R8: software mask replace, set, clear
    set_irq(32'd0);
    check_all("R8 idle");
    wr(38, 32'h0040_0001);
    rd(37, v); chk("R8 set alias", v, 32'h0040_0001);
    check_all("R8 soft set");
    wr(39, 32'h0040_0000);
    rd(37, v); chk("R8 clear alias", v, 32'h0000_0001);
    check_all("R8 soft clear");
    wr(37, 32'h0000_1000);
    check_all("R8 soft replace");

    // R9: writes to read-only and unused offsets leave state unchanged
    for (int a = 35; a < 64; a++)
      if (a == 35 || a == 36 || a == 41 || a >= 43) wr(a, 32'hFFFF_FFFF);
    sweep_reads("R9 ignored writes");
    check_all("R9 packet unchanged");

    // R10: write visible in packet one edge later
    wr(37, 32'd0);
    check_all("R10 idle");
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 6'd38; wdata_i = 32'h0000_0004;
    @(negedge clk);
    wr_en_i = 1'b0; m_sw = 32'h0000_0004;
    old_req = req_o;
    chk("R10 req not yet", 32'(old_req), 32'd0);
    @(negedge clk);
    chk("R10 req next edge", 32'(req_o), 32'd1);
    // R10: line change takes two edges to the packet
    wr(37, 32'd0);
    check_all("R10 cleared");
    @(negedge clk);
    irq_i = 32'h0000_0010;
    @(negedge clk);
    m_raw = 32'h0000_0010;
    chk("R10 line sampled only", 32'(req_o), 32'd0);
    @(negedge clk);
    chk("R10 line reaches packet", 32'(req_o), 32'd1);
    // R10: rdata holds while no read strobe
    rd(36, v);
    chk("R3 raw readback", v, 32'h0000_0010);
    @(negedge clk); addr_i = 6'd0;
    @(negedge clk); addr_i = 6'd41;
    @(negedge clk);
    chk("R10 rdata hold", rdata_o, 32'h0000_0010);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule